// File: doc/BRIEF.md
# Bus-Multiplexed Bidirectional GPIO Port

This block is a four-pin bidirectional general-purpose I/O port. Each pin has a direction bit and an output latch bit. Both are held in two byte-wide registers that a host reaches through a small register interface. The interface has a one-bit address, a write strobe and a read strobe. A direction bit of 1 makes its pin an input. A direction bit of 0 makes the pin an output that drives its latch value.

A mode input moves the port into system-bus mode. In that mode the three low pins stop following the registers. They carry the control outputs of an external address/data bus instead: an active-high address latch enable, an active-low output enable and an active-low write strobe. The values of these three controls come from a bus controller outside the block. The highest pin stays ordinary I/O in both modes.

Writes complete on the clock edge that samples the strobe, and reads are combinational. The host is therefore never stalled and there is no back-pressure. The pad side is modelled as three vectors: a drive value, a drive enable and the sampled pin level.

Top module: `gpio_busmux_port`

## Requirements
- R1: While reset is held, and right after it is released, every direction bit is 1, the output latch is 0 and no pin is driven (`pin_oe` = 0).
- R2: A write with `reg_addr`=0 updates only the output latch, from write-data bits 3:0, on the next clock edge. The direction bits are left unchanged.
- R3: A write with `reg_addr`=1 loads the direction bits from write-data bits 3:0 on the next clock edge.
- R4: In I/O mode (`bus_mode`=0), for each pin n, `pin_oe[n]` = NOT direction[n] and `pin_out[n]` = latch[n].
- R5: A read with `reg_addr`=0 returns the live pin levels `pin_in` in bits 3:0, not the latch contents.
- R6: Bits 7:4 of every read are 0, whatever was written to them. A read with `reg_addr`=1 returns the direction bits in bits 3:0.
- R7: In system-bus mode (`bus_mode`=1), pins 2:0 are driven whatever their direction bits say. Pin 0 carries `bus_ale`, pin 1 carries `bus_oe_n` and pin 2 carries `bus_wr_n`.
- R8: Pin 3 follows its direction and latch bits in both modes.
- R9: In system-bus mode, writes to the latch and direction bits are still stored. They do not change pins 2:0 until the port returns to I/O mode.
- R10: While `reg_rd` is 0, `reg_rdata` is 0.
- R11: If the latch is written before a pin is turned to output, the pin drives the written value from the first cycle after the direction write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 1 | 1 = system-bus mode, 0 = I/O mode |
| reg_addr | input | 1 | Register select: 0 = data, 1 = direction |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| bus_ale | input | 1 | Address latch enable from the bus controller |
| bus_oe_n | input | 1 | Active-low output enable from the bus controller |
| bus_wr_n | input | 1 | Active-low write strobe from the bus controller |
| pin_in | input | 4 | Sampled pad levels |
| pin_out | output | 4 | Pad drive values |
| pin_oe | output | 4 | Pad drive enables |

## Verification
The hardest case to reach is a register write made while the port is in system-bus mode. The stored value is hidden on pins 2:0 and shows up only after the mode is left. The stimulus writes both registers during bus mode, checks that the three bus pins keep following the controller, and reads the direction register back. It then drops the mode and checks that the new values appear on the pins. In a long random phase the bench also toggles the mode at random while writes go on. Its pad model loops driven pins back into `pin_in`, so reads of the data register see real pin levels rather than latch contents.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } reg_sel_e;

  // Bus control lines on the low pins: 0 = ALE, 1 = OE_n, 2 = WR_n
  localparam int unsigned NUM_BUS_CTL = 3;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else if (wr_en) begin
      if (sel == SEL_DIR) dir_q   <= wdata;
      else                latch_q <= wdata;
    end
  end

  assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata) && $stable(latch_q)));

  assert_data_keeps_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> (latch_q == $past(wdata) && $stable(dir_q)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dir_q) && $stable(latch_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic                   bus_mode,
  input  logic [NUM_BUS_CTL-1:0] bus_ctl,
  input  logic [PORT_W-1:0]      latch_q,
  input  logic [PORT_W-1:0]      dir_q,
  output logic [PORT_W-1:0]      pin_out,
  output logic [PORT_W-1:0]      pin_oe
);
  for (genvar n = 0; n < PORT_W; n++) begin : g_pin
    if (n < NUM_BUS_CTL) begin : g_shared
      always_comb begin
        if (bus_mode) begin
          pin_out[n] = bus_ctl[n];
          pin_oe[n]  = 1'b1;
        end else begin
          pin_out[n] = latch_q[n];
          pin_oe[n]  = ~dir_q[n];
        end
      end
    end else begin : g_plain
      assign pin_out[n] = latch_q[n];
      assign pin_oe[n]  = ~dir_q[n];
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [PORT_W-1:0] pin_in,
  input  logic [PORT_W-1:0] dir_q,
  output logic [REG_W-1:0]  rdata
);
  localparam int unsigned PAD_W = REG_W - PORT_W;

  logic [PORT_W-1:0] pick;

  always_comb begin
    pick  = (sel == SEL_DIR) ? dir_q : pin_in;
    rdata = rd_en ? {{PAD_W{1'b0}}, pick} : '0;
  end

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:PORT_W] == '0);

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: rtl/gpio_busmux_port.sv
module gpio_busmux_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_ale,
  input  logic              bus_oe_n,
  input  logic              bus_wr_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  reg_sel_e                 sel;
  logic [PORT_W-1:0]        latch_q;
  logic [PORT_W-1:0]        dir_q;
  logic [NUM_BUS_CTL-1:0]   bus_ctl;
  logic                     unused_wdata_hi;

  assign sel             = reg_sel_e'(reg_addr);
  assign bus_ctl         = {bus_wr_n, bus_oe_n, bus_ale};
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:PORT_W];

  gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .sel     (sel),
    .wdata   (reg_wdata[PORT_W-1:0]),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  gpio_pin_mux #(.PORT_W(PORT_W)) u_mux (
    .bus_mode (bus_mode),
    .bus_ctl  (bus_ctl),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  gpio_read_mux #(.PORT_W(PORT_W), .REG_W(REG_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (reg_rd),
    .sel    (sel),
    .pin_in (pin_in),
    .dir_q  (dir_q),
    .rdata  (reg_rdata)
  );

  assert_bus_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (pin_oe[NUM_BUS_CTL-1:0] == '1 &&
                  pin_out[0] == bus_ale && pin_out[1] == bus_oe_n &&
                  pin_out[2] == bus_wr_n));

  assert_top_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_DIR) |=> pin_oe[PORT_W-1] == ~$past(reg_wdata[PORT_W-1]));

  assert_data_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == SEL_DATA) |-> reg_rdata[PORT_W-1:0] == pin_in);
endmodule

// File: tb/gpio_busmux_port_tb.sv
module gpio_busmux_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_mode = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bus_ale = 1'b0;
  logic       bus_oe_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic [3:0] pin_in;
  logic [3:0] pin_out;
  logic [3:0] pin_oe;
  logic [3:0] ext_drv = 4'h0;

  integer n_chk = 0;
  integer n_err = 0;
  bit     cmp_on = 1'b0;

  // reference state
  logic [3:0] m_dir = 4'hF;
  logic [3:0] m_lat = 4'h0;

  always #10 clk = ~clk;

  // pad model: a driven pin reads back its drive value
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_drv);

  gpio_busmux_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_ale(bus_ale), .bus_oe_n(bus_oe_n), .bus_wr_n(bus_wr_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 4'hF;
      m_lat = 4'h0;
    end else if (reg_wr) begin
      if (reg_addr) m_dir = reg_wdata[3:0];
      else          m_lat = reg_wdata[3:0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [3:0] e_oe, e_out, e_pad;
      logic [2:0] ctl;
      ctl = {bus_wr_n, bus_oe_n, bus_ale};
      for (int n = 0; n < 4; n++) begin
        if (bus_mode && n < 3) begin
          e_oe[n] = 1'b1; e_out[n] = ctl[n];
        end else begin
          e_oe[n] = ~m_dir[n]; e_out[n] = m_lat[n];
        end
      end
      e_pad = (e_oe & e_out) | (~e_oe & ext_drv);
      if (bus_mode) chk("R7 bus pins", {2'b0, pin_oe[2:0], pin_out[2:0]}, {2'b0, e_oe[2:0], e_out[2:0]});
      else          chk("R4 io pins",  {2'b0, pin_oe[2:0], pin_out[2:0]}, {2'b0, e_oe[2:0], e_out[2:0]});
      chk("R8 pin3", {6'b0, pin_oe[3], pin_out[3]}, {6'b0, e_oe[3], e_out[3]});
      if (!reg_rd)       chk("R10 idle read", reg_rdata, 8'h00);
      else if (reg_addr) chk("R6 dir read",   reg_rdata, {4'h0, m_dir});
      else               chk("R5 data read",  reg_rdata, {4'h0, e_pad});
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_at(input logic a);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset oe", {4'h0, pin_oe}, 8'h00);
    chk("R1 reset out", {4'h0, pin_out}, 8'h00);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    rd_at(1'b1);
    chk("R1 dir after reset", reg_rdata, 8'h0F);
    reg_rd = 1'b0;
    cmp_on = 1'b1;

    wr(1'b0, 8'hA5);
    @(negedge clk);
    chk("R2 latch write leaves pins undriven", {4'h0, pin_oe}, 8'h00);
    rd_at(1'b1);
    chk("R2 dir unchanged", reg_rdata, 8'h0F);
    reg_rd = 1'b0;

    wr(1'b1, 8'h03);
    @(negedge clk);
    chk("R3 dir write oe", {4'h0, pin_oe}, 8'h0C);
    chk("R11 preset latch driven", {6'h0, pin_out[3:2]}, 8'h01);

    ext_drv = 4'b0011;
    rd_at(1'b0);
    chk("R5 reads pins not latch", reg_rdata, 8'h07);
    reg_rd = 1'b0;

    wr(1'b1, 8'hF0);
    rd_at(1'b1);
    chk("R6 upper write ignored", reg_rdata, 8'h00);
    reg_rd = 1'b0;

    #2 bus_mode = 1'b1; bus_ale = 1'b1; bus_oe_n = 1'b0; bus_wr_n = 1'b1;
    @(negedge clk);
    chk("R7 bus controls", {2'b0, pin_oe[2:0], pin_out[2:0]}, 8'h3D);
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h00);
    @(negedge clk);
    chk("R9 bus pins hold", {2'b0, pin_oe[2:0], pin_out[2:0]}, 8'h3D);
    chk("R8 pin3 input in bus mode", {7'h0, pin_oe[3]}, 8'h00);
    rd_at(1'b1);
    chk("R9 dir stored in bus mode", reg_rdata, 8'h0F);
    reg_rd = 1'b0;
    #2 bus_mode = 1'b0;
    @(negedge clk);
    chk("R9 stored values after leaving bus mode", {4'h0, pin_oe}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if ($urandom_range(0, 15) == 0) bus_mode = ~bus_mode;
      reg_addr  = 1'($urandom);
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_rd    = 1'($urandom);
      reg_wdata = 8'($urandom);
      bus_ale   = 1'($urandom);
      bus_oe_n  = 1'($urandom);
      bus_wr_n  = 1'($urandom);
      ext_drv   = 4'($urandom);
    end
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_rd = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule